// File: doc/BRIEF.md
# Four-Lane SD Block Read Receiver

This block takes read data from a memory card over a four-wire data bus and turns it into a stream of 32-bit words. A single pulse on the start input, carrying a block count from 1 to 256, arms the receiver. For every block it idles until all four lines are seen low together, which is the start nibble. It then takes 1024 data nibbles, packs them high nibble first and in arrival order into words, and collects 16 check nibbles. A single end nibble closes the block. Each data line has its own 16-bit CRC register, so a block carries 64 check bits. A block counts as bad if any of the four lines disagrees.

Progress is reported per block while later blocks are still arriving. A block counter, a byte counter and a CRC error counter all change on the edge that takes the last check nibble of a block. When the last block's end nibble has been taken, the receiver drops busy and pulses done, with a status of clean or CRC error. A cycle limit set by a parameter guards the whole transfer. When it runs out, the receiver stops listening to the bus, discards any partly packed word and reports a timeout. The read command and any host addressing are handled elsewhere.

Top module: `sd4_block_reader`

## Requirements
- R1: After reset, busy_o, done_o, word_valid_o, blocks_done_o, crc_errs_o and bytes_done_o are 0 and status_o is 0 (clean).
- R2: A start_i pulse while idle with blk_count_i between 1 and 256 sets busy_o on the next edge and clears the counters and the status. A count of 0 or above 256, or any start_i while busy, is ignored.
- R3: While it waits for a block, the receiver ignores every nibble except 4'b0000. The nibble after that start nibble is the first data nibble.
- R4: Each group of 8 data nibbles becomes one word. The first nibble goes in bits [31:28] and the last in [3:0]. word_valid_o rises on the edge that takes the eighth nibble, which gives 128 words for each 512-byte block.
- R5: While word_valid_o is high and word_ready_i is low, word_data_o holds its value and word_valid_o stays high. A word moves on the edge where both are high.
- R6: Each line k (bit k of sd_dat_i) feeds its own CRC16. The polynomial is x^16+x^12+x^5+1 (0x1021), the register starts at 0 and bits enter first in first out, with no final inversion. Check nibble j (0..15) carries, on line k, bit 15-j of that line's CRC.
- R7: blocks_done_o goes up by exactly one on the edge that takes the 16th check nibble of a block, and at no other time. bytes_done_o always equals blocks_done_o times 512.
- R8: On that same edge crc_errs_o goes up by one if any line's received check bits differ from the computed CRC.
- R9: After the last block's end nibble, busy_o falls and done_o pulses high for one cycle. status_o becomes 1 if crc_errs_o is not 0 and 0 otherwise, and it holds until the next accepted start.
- R10: If the transfer is still busy TIMEOUT_CYC edges after the start edge, busy_o falls, done_o pulses, status_o becomes 2 and any pending word is dropped. blocks_done_o keeps the blocks already completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, bus sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| blk_count_i | input | 9 | Number of blocks, 1..256 |
| sd_dat_i | input | 4 | Card data lines, one bit per line |
| word_ready_i | input | 1 | Consumer accepts the current word |
| word_valid_o | output | 1 | A packed word is present |
| word_data_o | output | 32 | Packed word, earliest nibble in the top bits |
| busy_o | output | 1 | Transfer in progress, bus being sampled |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 2 | 0 clean, 1 CRC error, 2 timeout |
| blocks_done_o | output | 9 | Blocks fully received in this transfer |
| crc_errs_o | output | 9 | Blocks whose CRC mismatched |
| bytes_done_o | output | 18 | Bytes of completed blocks |

## Verification
Properties checked on every cycle: a word is never overwritten while it is stalled, a stalled word stays stable, the block count only ever steps by one or returns to zero, the error count never exceeds the block count, and done never coincides with busy. The scenarios are needed for everything that depends on content and sequence. That covers the bit-exact word packing, the per-line CRC judgement including a single flipped check bit on one line, junk nibbles before a start nibble, ignored starts, and the exact edge on which the timeout fires. A behavioural model compares these with the ports on every clock.

// File: rtl/sd4_rx_pkg.sv
// Shared types for the four-lane block read receiver.
package sd4_rx_pkg;
    localparam int LANES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_CRC,
        ST_END
    } rx_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CRC     = 2'd1,
        RES_TIMEOUT = 2'd2
    } rx_result_e;
endpackage

// File: rtl/sd4_crc16_lane.sv
// One data line's CRC engine: it accumulates the CRC over the data bits
// and shifts in the received check bits. match_o compares both and counts
// the bit being presented now as the last check bit.
// Assumes that clr_i is pulsed before each block.
module sd4_crc16_lane #(
    parameter int                 CRC_W = 16,
    parameter logic [CRC_W-1:0]   POLY  = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic calc_en_i,
    input  logic cap_en_i,
    input  logic bit_i,
    output logic match_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] cap_q;
    logic             fb;

    assign fb = crc_q[CRC_W-1] ^ bit_i;

    // Purpose: update the running CRC and the received check bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_q <= '0;
            cap_q <= '0;
        end else begin
            if (calc_en_i)
                crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (POLY & {CRC_W{fb}});
            if (cap_en_i)
                cap_q <= {cap_q[CRC_W-2:0], bit_i};
        end
    end

    assign match_o = (crc_q == {cap_q[CRC_W-2:0], bit_i});
endmodule

// File: rtl/sd4_nibble_packer.sv
// Packs nibbles into words, earliest nibble in the top bits, and keeps a
// one-word output register with valid/ready. Assumes the consumer frees the
// register before the next word is complete.
module sd4_nibble_packer #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              nib_en_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o,
    output logic              word_done_o
);
    localparam int PER   = WORD_W / NIB_W;
    localparam int CNT_W = $clog2(PER);

    logic [WORD_W-NIB_W-1:0] sh_q;
    logic [CNT_W-1:0]        cnt_q;

    assign word_done_o = nib_en_i && (cnt_q == CNT_W'(PER - 1));

    // Purpose: collect nibbles and count the position inside the word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (nib_en_i) begin
            sh_q  <= {sh_q[WORD_W-2*NIB_W-1:0], nib_i};
            cnt_q <= word_done_o ? '0 : cnt_q + 1'b1;
        end
    end

    // Purpose: hold a finished word until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (word_done_o) begin
            valid_o <= 1'b1;
            data_o  <= {sh_q, nib_i};
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sd4_rx_ctrl.sv
// Transfer sequencer. It waits for a start nibble, counts the data and
// check nibbles, judges each block from the per-line match flags, keeps
// the counters and runs the transfer timeout. It assumes the bus stays
// high between blocks.
module sd4_rx_ctrl
    import sd4_rx_pkg::*;
#(
    parameter int MAX_BLOCKS  = 256,
    parameter int BLOCK_BYTES = 512,
    parameter int CRC_NIBS    = 16,
    parameter int TIMEOUT_CYC = 125000000,
    parameter int CNT_W       = $clog2(MAX_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] blk_count_i,
    input  logic [LANES-1:0] dat_i,
    input  logic [LANES-1:0] lane_match_i,
    output logic             crc_clr_o,
    output logic             crc_calc_o,
    output logic             crc_cap_o,
    output logic             pk_clr_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [CNT_W-1:0] blocks_o,
    output logic [CNT_W-1:0] errs_o
);
    localparam int DATA_NIBS = BLOCK_BYTES * 2;
    localparam int NIB_CW    = $clog2(DATA_NIBS);
    localparam int TMR_W     = $clog2(TIMEOUT_CYC + 1);

    rx_state_e        state_q;
    rx_result_e       status_q;
    logic [NIB_CW-1:0] nib_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] blocks_q;
    logic [CNT_W-1:0] errs_q;
    logic             done_q;
    logic             start_ok;
    logic             timeout_hit;
    logic             active;

    assign start_ok    = (state_q == ST_IDLE) && start_i && (blk_count_i != '0)
                         && (blk_count_i <= CNT_W'(MAX_BLOCKS));
    assign active      = (state_q != ST_IDLE);
    assign timeout_hit = active && (tmr_q == TMR_W'(TIMEOUT_CYC - 1));

    assign crc_clr_o  = start_ok || ((state_q == ST_WAIT) && (dat_i == '0));
    assign crc_calc_o = (state_q == ST_DATA) && !timeout_hit;
    assign crc_cap_o  = (state_q == ST_CRC) && !timeout_hit;
    assign pk_clr_o   = start_ok || timeout_hit;

    // Purpose: count transfer cycles for the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            tmr_q <= '0;
        else
            tmr_q <= tmr_q + 1'b1;
    end

    // Purpose: sequence the blocks, judge CRCs and keep the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= RES_OK;
            nib_q    <= '0;
            total_q  <= '0;
            blocks_q <= '0;
            errs_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (timeout_hit) begin
                state_q  <= ST_IDLE;
                status_q <= RES_TIMEOUT;
                done_q   <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: if (start_ok) begin
                        state_q  <= ST_WAIT;
                        total_q  <= blk_count_i;
                        blocks_q <= '0;
                        errs_q   <= '0;
                        status_q <= RES_OK;
                    end
                    ST_WAIT: if (dat_i == '0) begin
                        state_q <= ST_DATA;
                        nib_q   <= '0;
                    end
                    ST_DATA: if (nib_q == NIB_CW'(DATA_NIBS - 1)) begin
                        state_q <= ST_CRC;
                        nib_q   <= '0;
                    end else begin
                        nib_q <= nib_q + 1'b1;
                    end
                    ST_CRC: if (nib_q == NIB_CW'(CRC_NIBS - 1)) begin
                        state_q  <= ST_END;
                        blocks_q <= blocks_q + 1'b1;
                        if (!(&lane_match_i))
                            errs_q <= errs_q + 1'b1;
                    end else begin
                        nib_q <= nib_q + 1'b1;
                    end
                    ST_END: if (blocks_q == total_q) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        status_q <= (errs_q != '0) ? RES_CRC : RES_OK;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy_o   = active;
    assign done_o   = done_q;
    assign status_o = status_q;
    assign blocks_o = blocks_q;
    assign errs_o   = errs_q;
endmodule

// File: rtl/sd4_block_reader.sv
// Top level of the four-lane block read receiver. It joins the sequencer,
// one CRC engine per data line and the word packer. Assumes sd_dat_i is
// already synchronous to clk.
module sd4_block_reader
    import sd4_rx_pkg::*;
#(
    parameter int MAX_BLOCKS  = 256,
    parameter int BLOCK_BYTES = 512,
    parameter int WORD_W      = 32,
    parameter int CRC_W       = 16,
    parameter int TIMEOUT_CYC = 125000000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [$clog2(MAX_BLOCKS+1)-1:0] blk_count_i,
    input  logic [3:0]                   sd_dat_i,
    input  logic                         word_ready_i,
    output logic                         word_valid_o,
    output logic [WORD_W-1:0]            word_data_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [1:0]                   status_o,
    output logic [$clog2(MAX_BLOCKS+1)-1:0] blocks_done_o,
    output logic [$clog2(MAX_BLOCKS+1)-1:0] crc_errs_o,
    output logic [$clog2(MAX_BLOCKS+1)+$clog2(BLOCK_BYTES)-1:0] bytes_done_o
);
    localparam int CNT_W    = $clog2(MAX_BLOCKS + 1);
    localparam int BSH      = $clog2(BLOCK_BYTES);
    localparam int CRC_NIBS = CRC_W;

    logic             crc_clr, crc_calc, crc_cap, pk_clr, word_done;
    logic [LANES-1:0] lane_match;

    sd4_rx_ctrl #(
        .MAX_BLOCKS (MAX_BLOCKS),
        .BLOCK_BYTES(BLOCK_BYTES),
        .CRC_NIBS   (CRC_NIBS),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .blk_count_i (blk_count_i),
        .dat_i       (sd_dat_i),
        .lane_match_i(lane_match),
        .crc_clr_o   (crc_clr),
        .crc_calc_o  (crc_calc),
        .crc_cap_o   (crc_cap),
        .pk_clr_o    (pk_clr),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .status_o    (status_o),
        .blocks_o    (blocks_done_o),
        .errs_o      (crc_errs_o)
    );

    // One independent CRC engine per data line.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sd4_crc16_lane #(.CRC_W(CRC_W)) u_crc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (crc_clr),
            .calc_en_i(crc_calc),
            .cap_en_i (crc_cap),
            .bit_i    (sd_dat_i[k]),
            .match_o  (lane_match[k])
        );
    end

    sd4_nibble_packer #(.WORD_W(WORD_W), .NIB_W(LANES)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (pk_clr),
        .nib_en_i   (crc_calc),
        .nib_i      (sd_dat_i),
        .ready_i    (word_ready_i),
        .valid_o    (word_valid_o),
        .data_o     (word_data_o),
        .word_done_o(word_done)
    );

    assign bytes_done_o = {blocks_done_o, {BSH{1'b0}}};
endmodule

// File: rtl/sd4_block_reader_chk.sv
// Property checker for the block read receiver, bound to the top level.
module sd4_block_reader_chk #(
    parameter int CNT_W  = 9,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid_o,
    input logic              word_ready_i,
    input logic [WORD_W-1:0] word_data_o,
    input logic              word_done,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  blocks_done_o,
    input logic [CNT_W-1:0]  crc_errs_o
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |-> !word_done); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |=> ((word_valid_o && $stable(word_data_o)) || !busy_o)); // R5

    AST_WORD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid_o) |-> busy_o); // R4

    AST_BLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blocks_done_o) |-> ((blocks_done_o == $past(blocks_done_o) + 1'b1) || (blocks_done_o == '0))); // R7

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        crc_errs_o <= blocks_done_o); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
endmodule

bind sd4_block_reader sd4_block_reader_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid_o (word_valid_o),
    .word_ready_i (word_ready_i),
    .word_data_o  (word_data_o),
    .word_done    (word_done),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .blocks_done_o(blocks_done_o),
    .crc_errs_o   (crc_errs_o)
);

// File: tb/sd4_block_reader_bench.sv
// Bench: a behavioural model advanced on each rising edge and compared with
// the ports on every falling edge, plus scenario checks.
module sd4_block_reader_bench;
    localparam int TO = 6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  blk_count_i = '0;
    logic [3:0]  sd_dat_i = 4'hF;
    logic        word_ready_i = 1'b1;
    logic        word_valid_o;
    logic [31:0] word_data_o;
    logic        busy_o, done_o;
    logic [1:0]  status_o;
    logic [8:0]  blocks_done_o, crc_errs_o;
    logic [17:0] bytes_done_o;

    always #4 clk = ~clk;

    sd4_block_reader #(.TIMEOUT_CYC(TO)) u_sd4_block_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_count_i(blk_count_i),
        .sd_dat_i(sd_dat_i), .word_ready_i(word_ready_i), .word_valid_o(word_valid_o),
        .word_data_o(word_data_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .blocks_done_o(blocks_done_o), .crc_errs_o(crc_errs_o), .bytes_done_o(bytes_done_o)
    );

    int tests = 0, fails = 0, words_seen = 0;
    bit ready_gate = 1'b0;
    int rcyc = 0;
    bit bad_blk [0:15];

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // consumer stall pattern
    always @(negedge clk) begin
        rcyc++;
        word_ready_i = ready_gate ? ((rcyc % 11) < 8) : 1'b1;
    end

    // behavioural model
    int m_st = 0, m_nib = 0, m_total = 0, m_blk = 0, m_err = 0, m_tmr = 0, m_status = 0, m_an = 0;
    bit m_done = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] exp_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_blk = 0; m_err = 0; m_status = 0; m_done = 0; m_tmr = 0; m_an = 0;
            exp_q.delete();
        end else begin
            m_done = 0;
            if (m_st != 0 && m_tmr == TO - 1) begin
                m_st = 0; m_status = 2; m_done = 1; m_an = 0;
                exp_q.delete();
            end else begin
                if (m_st != 0) m_tmr++;
                case (m_st)
                    0: if (start_i && blk_count_i >= 1 && blk_count_i <= 256) begin
                        m_st = 1; m_total = blk_count_i; m_blk = 0; m_err = 0;
                        m_status = 0; m_tmr = 0; m_an = 0; exp_q.delete();
                    end
                    1: if (sd_dat_i == 4'h0) begin m_st = 2; m_nib = 0; end
                    2: begin
                        m_acc = {m_acc[27:0], sd_dat_i};
                        m_an++;
                        if (m_an == 8) begin exp_q.push_back(m_acc); m_an = 0; end
                        m_nib++;
                        if (m_nib == 1024) begin m_st = 3; m_nib = 0; end
                    end
                    3: begin
                        m_nib++;
                        if (m_nib == 16) begin
                            m_blk++;
                            if (bad_blk[m_blk-1]) m_err++;
                            m_st = 4;
                        end
                    end
                    default: if (m_blk == m_total) begin
                        m_st = 0; m_done = 1; m_status = (m_err != 0) ? 1 : 0;
                    end else m_st = 1;
                endcase
            end
        end
    end

    // per-cycle comparison with the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                check(busy_o == (m_st != 0), "R2 busy", busy_o, m_st != 0);
                check(blocks_done_o == m_blk, "R7 blocks_done", blocks_done_o, m_blk);
                check(bytes_done_o == m_blk * 512, "R7 bytes_done", bytes_done_o, m_blk * 512);
                check(crc_errs_o == m_err, "R8 crc_errs", crc_errs_o, m_err);
                check(done_o == m_done, "R9 done", done_o, m_done);
                check(status_o == m_status, "R10 status", status_o, m_status);
                if (word_valid_o && word_ready_i) begin
                    words_seen++;
                    if (exp_q.size() == 0) check(1'b0, "R4 unexpected word", word_data_o, 0);
                    else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(word_data_o == e, "R4 word data", word_data_o, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic drive(input logic [3:0] n);
        @(negedge clk);
        sd_dat_i = n;
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        start_i = 1'b1;
        blk_count_i = 9'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    logic [3:0]  blk_nib [0:1023];
    logic [15:0] lane_crc [0:3];

    task automatic send_block(input int seed, input int bad_lane);
        logic [7:0] b;
        logic [3:0] n;
        for (int i = 0; i < 512; i++) begin
            b = 8'(seed * 29 + i * 7 + (i >> 4));
            blk_nib[2*i]   = b[7:4];
            blk_nib[2*i+1] = b[3:0];
        end
        for (int k = 0; k < 4; k++) lane_crc[k] = 16'h0;
        for (int i = 0; i < 1024; i++)
            for (int k = 0; k < 4; k++) lane_crc[k] = crc_step(lane_crc[k], blk_nib[i][k]);
        drive(4'hF); drive(4'hF);
        drive(4'hA); drive(4'h5);          // R3: junk before the start nibble
        drive(4'h0);
        for (int i = 0; i < 1024; i++) drive(blk_nib[i]);
        for (int j = 0; j < 16; j++) begin
            for (int k = 0; k < 4; k++) n[k] = lane_crc[k][15-j];
            if (bad_lane >= 0 && j == 5) n[bad_lane] = ~n[bad_lane];
            drive(n);
        end
        drive(4'hF);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            #1;
            n++;
        end
        check(done_o == 1'b1, "R9 done pulse seen", done_o, 1);
        @(negedge clk);
        #1;
    endtask

    initial begin
        logic [15:0] c;
        logic [7:0]  ch;
        for (int i = 0; i < 16; i++) bad_blk[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(!busy_o && !done_o && !word_valid_o, "R1 idle flags", {busy_o, done_o, word_valid_o}, 0);
        check(blocks_done_o == 0 && crc_errs_o == 0 && bytes_done_o == 0, "R1 counters",
              blocks_done_o + crc_errs_o, 0);
        check(status_o == 2'd0, "R1 status", status_o, 0);

        // R6 known vector for the bench's CRC ("123456789" -> 0x31C3)
        c = 16'h0;
        for (int i = 0; i < 9; i++) begin
            ch = 8'h31 + 8'(i);
            for (int j = 7; j >= 0; j--) c = crc_step(c, ch[j]);
        end
        check(c == 16'h31C3, "R6 crc reference vector", c, 16'h31C3);

        // R2 bad counts are ignored
        pulse_start(0);
        pulse_start(300);
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o, "R2 out-of-range count ignored", busy_o, 0);

        // single clean block
        words_seen = 0;
        pulse_start(1);
        send_block(1, -1);
        wait_done();
        check(status_o == 2'd0, "R9 clean status", status_o, 0);
        check(blocks_done_o == 1 && bytes_done_o == 512, "R7 one block", bytes_done_o, 512);
        check(words_seen == 128, "R4 word count one block", words_seen, 128);

        // three blocks, second one corrupted on line 2, with stalls
        ready_gate = 1'b1;
        bad_blk[1] = 1'b1;
        words_seen = 0;
        pulse_start(3);
        send_block(2, -1);
        #1;
        check(blocks_done_o == 1, "R7 progress mid-transfer", blocks_done_o, 1);
        pulse_start(5);                       // R2: ignored while busy
        send_block(3, 2);
        #1;
        check(crc_errs_o == 1, "R8 error counted on bad block", crc_errs_o, 1);
        send_block(4, -1);
        wait_done();
        check(status_o == 2'd1, "R8 crc error status", status_o, 1);
        check(blocks_done_o == 3 && bytes_done_o == 1536, "R7 three blocks", bytes_done_o, 1536);
        check(crc_errs_o == 1, "R8 single error", crc_errs_o, 1);
        check(words_seen == 384, "R5 words through stalls", words_seen, 384);
        ready_gate = 1'b0;
        bad_blk[1] = 1'b0;

        // timeout: two blocks asked, one sent
        pulse_start(2);
        send_block(5, -1);
        wait_done();
        check(status_o == 2'd2, "R10 timeout status", status_o, 2);
        check(!busy_o && blocks_done_o == 1, "R10 stops with progress kept", blocks_done_o, 1);
        check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule